// File: doc/BRIEF.md
# Lockout Keyboard Scanner with Debounce

This block scans a switch matrix of up to 64 keys, one scan position at a time. It drives a 4-bit scan code, either straight to 16 switches or through an external 1-of-16 decoder, and samples four return lines. A return line reads 1 when the switch at the current scan position is closed.

The first closed key found is parked on and debounced. After that its 6-bit address is latched. A ready flag and an active-low interrupt then stay asserted until the command engine issues a fetch. The fetch copies the flag and the address into an 8-bit output register and clears the flag.

Scanning is locked out while a key is latched or still held. A second key pressed together with the first is reported only after the first has been fetched and released. Two configuration inputs set the matrix mode (16 or 64 keys) and turn scanning on or off.

Top module: `keyscan_lockout`

## Requirements
- R1: While scanning with no key found, `scanCode` advances by one every `SCAN_STEP` clock cycles and wraps from 15 to 0. One sample of the return lines is taken at the end of each step.
- R2: With `wideMode`=1 (64 keys), the key address is 16 × (return line index) + `scanCode`, so the line index sits in bits 5:4 and the scan code in bits 3:0. When several lines are closed at one scan code, the lowest-numbered line is taken.
- R3: With `wideMode`=0 (16 keys), only return line 0 is sampled, and address bits 5:4 are reported as 0.
- R4: A key is latched only if it reads closed at its detection sample and at `DEBOUNCE` further consecutive samples, one sample per `SCAN_STEP` cycles. A shorter closure is dropped and is never reported.
- R5: When a key is latched, `keyReady` goes to 1 and `kbIrqN` goes to 0. Both hold, even after the key is released, until a fetch.
- R6: A fetch (`fetchReq`=1 at a clock edge) loads `keyData` at that edge with bit 7 = `keyReady`, bit 6 = 0 and bits 5:0 = the latched address. From the next cycle `keyReady` is 0 and `kbIrqN` is 1.
- R7: While a key is latched and not yet fetched, or is still closed, no other key is reported. Scanning resumes only after the latched key has been fetched and has read open for `DEBOUNCE` consecutive samples.
- R8: While `scanOff`=1, `scanCode` holds its value and no key is detected. When `scanOff` returns to 0, scanning resumes at the held position.
- R9: After reset, `scanCode`=0, `keyReady`=0, `kbIrqN`=1 and `keyData`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| scanOff | input | 1 | 1 stops scanning, 0 runs it |
| wideMode | input | 1 | 1 selects the 64-key matrix, 0 the 16-key matrix |
| retLines | input | 4 | Return lines, 1 = switch closed at the current scan position |
| fetchReq | input | 1 | Fetch strobe from the command engine |
| scanCode | output | 4 | Current scan position |
| keyData | output | 8 | Output register: {flag, 0, address} |
| keyReady | output | 1 | Key latched and not yet fetched |
| kbIrqN | output | 1 | Interrupt, active low, asserted while `keyReady` is 1 |

## Verification
The bench models the matrix as 64 switch bits and derives the return lines from the live scan code, so every pattern goes through the real scan timing.

- A single key on an upper return line in 64-key mode checks that the line index lands in bits 5:4 and the scan code in bits 3:0.
- The same upper-line key in 16-key mode must be ignored, which separates the two modes.
- A two-sample closure must be rejected while a long one is accepted, which pins down the length of the debounce window.
- Two keys closed at one scan code check line priority and the lockout: the second key appears only after the first is fetched and released.
- A key pressed while scanning is off checks that the scan position freezes.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int CODE_W = 4;
  localparam int LINES  = 4;
  localparam int ADDR_W = 6;

  typedef enum logic [1:0] {
    ST_SCAN     = 2'd0,
    ST_DEBOUNCE = 2'd1,
    ST_HELD     = 2'd2
  } scanState_t;

  typedef struct packed {
    logic advance;   // step to next scan position
    logic loadCand;  // capture candidate address
    logic clrCnt;    // zero the sample counter
    logic incCnt;    // count one sample
    logic latchKey;  // candidate becomes the reported key
  } scanStrobes_t;
endpackage

// File: rtl/keyscan_datapath.sv
module keyscan_datapath
  import keyscan_pkg::*;
#(
  parameter int SCAN_STEP = 2500,
  parameter int DEBOUNCE  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scanOff,
  input  logic               wideMode,
  input  logic [LINES-1:0]   retLines,
  input  logic               fetchReq,
  input  scanStrobes_t       str,
  output logic               tick,
  output logic               hit,
  output logic               candClosed,
  output logic               cntDone,
  output logic [CODE_W-1:0]  scanCode,
  output logic [7:0]         keyData,
  output logic               keyReady
);
  localparam int STEP_W = (SCAN_STEP > 1) ? $clog2(SCAN_STEP) : 1;
  localparam int DB_W   = $clog2(DEBOUNCE + 1);

  logic [STEP_W-1:0] stepCnt;
  logic [DB_W-1:0]   dbCnt;
  logic [ADDR_W-1:0] candAddr, keyAddr;
  logic [1:0]        hitLine;
  logic [LINES-1:0]  liveLines;

  // step timer: one sample per SCAN_STEP cycles while enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepCnt <= '0;
    else if (scanOff || tick) stepCnt <= '0;
    else stepCnt <= stepCnt + 1'b1;
  end
  assign tick = !scanOff && (stepCnt == STEP_W'(SCAN_STEP - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) scanCode <= '0;
    else if (str.advance) scanCode <= scanCode + 1'b1;
  end

  // narrow mode only looks at line 0
  assign liveLines = wideMode ? retLines : {{(LINES-1){1'b0}}, retLines[0]};
  assign hit = |liveLines;

  always_comb begin
    hitLine = 2'd0;
    for (int i = LINES - 1; i >= 0; i--)
      if (liveLines[i]) hitLine = 2'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) candAddr <= '0;
    else if (str.loadCand) candAddr <= {hitLine, scanCode};
  end
  assign candClosed = retLines[candAddr[5:4]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dbCnt <= '0;
    else if (str.clrCnt) dbCnt <= '0;
    else if (str.incCnt) dbCnt <= dbCnt + 1'b1;
  end
  assign cntDone = (dbCnt == DB_W'(DEBOUNCE - 1));

  // reported key, flag and output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyAddr  <= '0;
      keyReady <= 1'b0;
      keyData  <= '0;
    end else begin
      if (fetchReq) begin
        keyData  <= {keyReady, 1'b0, keyAddr};
        keyReady <= 1'b0;
      end
      if (str.latchKey) begin
        keyAddr  <= candAddr;
        keyReady <= 1'b1;
      end
    end
  end

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    scanOff |=> $stable(scanCode));
  p_fetch_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !str.latchKey) |=> !keyReady);
  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rstN)
    (str.latchKey && !wideMode && $past(!wideMode)) |=> (keyAddr[5:4] == 2'b00));
endmodule

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
  import keyscan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         scanOff,
  input  logic         tick,
  input  logic         hit,
  input  logic         candClosed,
  input  logic         cntDone,
  input  logic         keyReady,
  output scanStrobes_t str
);
  scanState_t state, nextState;

  always_comb begin
    str       = '0;
    nextState = state;
    unique case (state)
      ST_SCAN: if (tick) begin
        if (hit) begin
          str.loadCand = 1'b1;
          str.clrCnt   = 1'b1;
          nextState    = ST_DEBOUNCE;
        end else begin
          str.advance = 1'b1;
        end
      end
      ST_DEBOUNCE: begin
        if (scanOff) nextState = ST_SCAN;
        else if (tick) begin
          if (!candClosed) begin
            str.advance = 1'b1;
            nextState   = ST_SCAN;
          end else if (cntDone) begin
            str.latchKey = 1'b1;
            str.clrCnt   = 1'b1;
            nextState    = ST_HELD;
          end else begin
            str.incCnt = 1'b1;
          end
        end
      end
      ST_HELD: if (tick) begin
        if (candClosed) str.clrCnt = 1'b1;
        else if (!cntDone) str.incCnt = 1'b1;
        else if (!keyReady) begin
          str.advance = 1'b1;
          str.clrCnt  = 1'b1;
          nextState   = ST_SCAN;
        end
      end
      default: nextState = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SCAN;
    else state <= nextState;
  end

  p_advance_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    str.advance |-> tick);
  p_latch_closed_r4: assert property (@(posedge clk) disable iff (!rstN)
    str.latchKey |-> candClosed);
  p_held_lockout_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HELD && keyReady) |-> (!str.loadCand && !str.advance));
endmodule

// File: rtl/keyscan_lockout.sv
module keyscan_lockout
  import keyscan_pkg::*;
#(
  parameter int SCAN_STEP = 2500,
  parameter int DEBOUNCE  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scanOff,
  input  logic       wideMode,
  input  logic [3:0] retLines,
  input  logic       fetchReq,
  output logic [3:0] scanCode,
  output logic [7:0] keyData,
  output logic       keyReady,
  output logic       kbIrqN
);
  scanStrobes_t str;
  logic tick, hit, candClosed, cntDone;

  keyscan_datapath #(.SCAN_STEP(SCAN_STEP), .DEBOUNCE(DEBOUNCE)) u_dp (
    .clk(clk), .rstN(rstN), .scanOff(scanOff), .wideMode(wideMode),
    .retLines(retLines), .fetchReq(fetchReq), .str(str), .tick(tick),
    .hit(hit), .candClosed(candClosed), .cntDone(cntDone),
    .scanCode(scanCode), .keyData(keyData), .keyReady(keyReady)
  );

  keyscan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .scanOff(scanOff), .tick(tick), .hit(hit),
    .candClosed(candClosed), .cntDone(cntDone), .keyReady(keyReady),
    .str(str)
  );

  assign kbIrqN = ~keyReady;
endmodule

// File: tb/keyscan_lockout_test.sv
module keyscan_lockout_test;
  localparam int STEP = 4;
  localparam int DB   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanOff = 1'b0;
  logic wideMode = 1'b1;
  logic fetchReq = 1'b0;
  logic [3:0] retLines;
  logic [3:0] scanCode;
  logic [7:0] keyData;
  logic keyReady, kbIrqN;
  logic [63:0] keys = '0;
  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;  // 125 MHz

  keyscan_lockout #(.SCAN_STEP(STEP), .DEBOUNCE(DB)) uut (
    .clk(clk), .rstN(rstN), .scanOff(scanOff), .wideMode(wideMode),
    .retLines(retLines), .fetchReq(fetchReq), .scanCode(scanCode),
    .keyData(keyData), .keyReady(keyReady), .kbIrqN(kbIrqN)
  );

  // switch matrix: line l at code c is key l*16+c
  always_comb
    for (int l = 0; l < 4; l++) retLines[l] = keys[l * 16 + int'(scanCode)];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitReady(input int maxCyc);
    for (int i = 0; i < maxCyc && !keyReady; i++) @(negedge clk);
  endtask

  task automatic fetch();
    fetchReq = 1'b1;
    @(negedge clk);
    fetchReq = 1'b0;
  endtask

  task automatic t_reset();
    check(scanCode == 4'd0, "R9 scanCode", scanCode, 0);
    check(keyReady == 1'b0 && kbIrqN == 1'b1, "R9 flags", {keyReady, kbIrqN}, 1);
    check(keyData == 8'h00, "R9 keyData", keyData, 0);
  endtask

  task automatic t_scanStep();
    logic [3:0] c0;
    c0 = scanCode;
    for (int i = 0; i < 2 * STEP && scanCode == c0; i++) @(negedge clk);
    c0 = scanCode;
    cycles(STEP - 1);
    check(scanCode == c0, "R1 hold within step", scanCode, c0);
    cycles(1);
    check(scanCode == 4'(c0 + 1), "R1 advance", scanCode, 4'(c0 + 1));
    cycles(STEP * 16);
    check(scanCode == 4'(c0 + 1), "R1 wrap after 16 steps", scanCode, 4'(c0 + 1));
  endtask

  task automatic t_wideKey();
    keys[42] = 1'b1;  // line 2, code 10
    waitReady(300);
    check(keyReady && !kbIrqN, "R5 flag set", {keyReady, kbIrqN}, 2);
    cycles(40);
    keys[42] = 1'b0;
    cycles(40);
    check(keyReady && !kbIrqN, "R5 flag held until fetch", {keyReady, kbIrqN}, 2);
    fetch();
    check(keyData == 8'hAA, "R2 R6 fetched data", keyData, 8'hAA);
    check(!keyReady && kbIrqN, "R6 flag cleared", {keyReady, kbIrqN}, 1);
    fetch();
    check(keyData[7:6] == 2'b00, "R6 empty fetch bit7", keyData, 8'h2A);
    cycles(STEP * (DB + 2));
  endtask

  task automatic t_narrow();
    wideMode = 1'b0;
    keys[35] = 1'b1;  // line 2, code 3: invisible in 16-key mode
    cycles(300);
    check(!keyReady, "R3 upper line ignored", keyReady, 0);
    keys[35] = 1'b0;
    keys[7] = 1'b1;
    keys[23] = 1'b1;  // line 1, same code, ignored
    waitReady(300);
    keys[7] = 1'b0;
    keys[23] = 1'b0;
    fetch();
    check(keyData == 8'h87, "R3 narrow address", keyData, 8'h87);
    cycles(STEP * (DB + 2));
    wideMode = 1'b1;
  endtask

  task automatic t_bounce();
    for (int i = 0; i < 40 * STEP && scanCode != 4'd5; i++) @(negedge clk);
    keys[5] = 1'b1;
    cycles(2 * STEP);
    keys[5] = 1'b0;
    cycles(150);
    check(!keyReady, "R4 short closure dropped", keyReady, 0);
    keys[5] = 1'b1;
    waitReady(300);
    check(keyReady, "R4 long closure latched", keyReady, 1);
    keys[5] = 1'b0;
    fetch();
    check(keyData == 8'h85, "R4 debounced address", keyData, 8'h85);
    cycles(STEP * (DB + 2));
  endtask

  task automatic t_lockout();
    keys[2] = 1'b1;
    keys[18] = 1'b1;  // same code, line 1
    waitReady(300);
    fetch();
    check(keyData == 8'h82, "R2 lowest line wins", keyData, 8'h82);
    cycles(150);
    check(!keyReady, "R7 second key locked out while first held", keyReady, 0);
    keys[2] = 1'b0;
    waitReady(300);
    fetch();
    check(keyData == 8'h92, "R7 queued key after release", keyData, 8'h92);
    keys[18] = 1'b0;
    cycles(STEP * (DB + 2));
    keys[9] = 1'b1;
    waitReady(300);
    keys[9] = 1'b0;
    keys[11] = 1'b1;
    cycles(150);
    check(keyReady && keyData[5:0] != 6'd11, "R7 no new key before fetch", keyReady, 1);
    fetch();
    check(keyData == 8'h89, "R7 first key kept", keyData, 8'h89);
    waitReady(300);
    fetch();
    check(keyData == 8'h8B, "R7 next key after fetch", keyData, 8'h8B);
    keys[11] = 1'b0;
    cycles(STEP * (DB + 2));
  endtask

  task automatic t_scanOff();
    logic [3:0] c0;
    scanOff = 1'b1;
    @(negedge clk);
    c0 = scanCode;
    keys[c0] = 1'b1;
    cycles(100);
    check(scanCode == c0, "R8 code frozen", scanCode, c0);
    check(!keyReady, "R8 no detection", keyReady, 0);
    scanOff = 1'b0;
    waitReady(300);
    fetch();
    check(keyData == {2'b10, 2'b00, c0}, "R8 resume at held code", keyData, {2'b10, 2'b00, c0});
    keys[c0] = 1'b0;
    cycles(STEP * (DB + 2));
  endtask

  initial begin
    cycles(3);
    t_reset();
    rstN = 1'b1;
    t_scanStep();
    t_wideKey();
    t_narrow();
    t_bounce();
    t_lockout();
    t_scanOff();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule